// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the address side of a multi-register load or store. A single start pulse captures a 16-bit register list, a 32-bit base value, the index of the base register, four option flags (pre-index, upward, writeback, load) and a variant select. The block then issues one beat per clock. Each beat carries the index of the register to move and the word address for it, and the registers go out in ascending index order. After the last beat it raises a one-cycle done pulse that carries the final base value and whether that value must be written to the base register. On a store with writeback whose list holds the base register, the beat for that register also carries the value to store in place of the register contents.

The sequencer is built around three states. ST_IDLE waits for start. Start with a non-empty effective list takes it to ST_BEAT, and start with an empty effective list takes it to ST_DONE. ST_BEAT issues one beat per cycle, stays in ST_BEAT while bits remain, and moves to ST_DONE after the last one. ST_DONE presents the writeback result for one cycle and always returns to ST_IDLE. The block samples start only in ST_IDLE. The surrounding core supplies the memory access, the register file and the instruction decode.

An empty register list is a special case. The older variant moves register 15 alone. The newer variant moves nothing. Both variants move the base by sixteen words.

Top module: `blk_xfer_seq`

## Requirements
- R1: For an upward transfer (up_i=1) with a non-empty list, the first beat address is base+4 when pre_i=1 and base when pre_i=0.
- R2: For a downward transfer (up_i=0) with a non-empty list, the first beat address is base-4*count when pre_i=1 and base-4*count+4 when pre_i=0, where count is the number of set bits in the list.
- R3: Beats start in the cycle after start and come one per cycle with no gaps. beat_reg_o steps through the set bits of the list in ascending order, and beat_addr_o grows by 4 on each beat.
- R4: done_o is high for exactly one cycle, the cycle after the last beat. No beat is valid in that cycle. With a non-empty list, wb_val_o is base+4*count when up_i=1 and base-4*count when up_i=0.
- R5: With a non-empty list, wb_en_o is 1 on done when wb_i=1 and the transfer is a store, or when wb_i=1 and the base register is not in the list. wb_en_o is 0 when wb_i=0.
- R6: On a load (load_i=1) with writeback, if the base register is in the list, wb_en_o is 0 on done.
- R7: With variant_i=0 (older) and an empty list, exactly one beat is issued, for register 15. Its address is base+(pre_i?4:0) going up and base-(0x40-(pre_i?0:4)) going down.
- R8: With variant_i=1 (newer) and an empty list, no beat is issued and done_o rises in the cycle after start.
- R9: With an empty list, done_o carries wb_en_o=1 and wb_val_o=base+0x40 when up_i=1 or base-0x40 when up_i=0, whatever wb_i and load_i are.
- R10: With variant_i=0, on a store with writeback whose list holds the base register, the beat for that register has st_sub_en_o=1. st_sub_val_o is the old base if that register is the lowest set bit of the list, and the final base otherwise. st_sub_en_o is 0 on every other beat.
- R11: With variant_i=1, on a store with writeback whose list holds the base register, the beat for that register has st_sub_en_o=1 and st_sub_val_o equal to the old base.
- R12: The block ignores start while it is in ST_BEAT or ST_DONE. The running sequence goes on unchanged, and no extra beat or done follows it.
- R13: After reset, beat_valid_o, done_o, wb_en_o and st_sub_en_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request; sampled only in ST_IDLE |
| rlist_i | input | 16 | Register list, bit n selects register n |
| base_i | input | 32 | Base register value |
| base_idx_i | input | 4 | Index of the base register |
| pre_i | input | 1 | Address is stepped before the first access |
| up_i | input | 1 | 1 = ascending addresses, 0 = descending |
| wb_i | input | 1 | Base writeback requested |
| load_i | input | 1 | 1 = load, 0 = store |
| variant_i | input | 1 | 0 = older variant, 1 = newer variant |
| beat_valid_o | output | 1 | Beat strobe |
| beat_reg_o | output | 4 | Register index of the beat |
| beat_addr_o | output | 32 | Word address of the beat |
| st_sub_en_o | output | 1 | Store this beat with st_sub_val_o in place of the register |
| st_sub_val_o | output | 32 | Substitute store value |
| done_o | output | 1 | Sequence complete, writeback result valid |
| wb_en_o | output | 1 | Write wb_val_o to the base register |
| wb_val_o | output | 32 | Final base value |

## Verification
Beat k of a sequence is due k+1 cycles after the edge that samples start. done_o is due one cycle after the last beat, or one cycle after start when the sequence has no beats. Each scenario task drives its inputs on a falling edge and then reads the outputs on the falling edge of every following cycle, checking each beat against a position computed from the flags. A start pulse injected during the beats and another during done test that the timing holds: the bench then expects one quiet ST_IDLE cycle with no beat and no done.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    typedef enum logic {
        VAR_OLD = 1'b0,
        VAR_NEW = 1'b1
    } arch_var_t;

endpackage

// File: rtl/blkseq_popcnt.sv
module blkseq_popcnt #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/blkseq_lowbit.sv
module blkseq_lowbit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [W-1:0]  hot_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < W; g++) begin : g_chain
        assign seen[g+1] = seen[g] | vec_i[g];
        assign hot_o[g]  = vec_i[g] & ~seen[g];
    end

    assign any_o = seen[W];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (hot_o[i]) idx_o = idx_o | IW'(i);
        end
    end
endmodule

// File: rtl/blkseq_addr_calc.sv
module blkseq_addr_calc #(
    parameter int AW   = 32,
    parameter int CW   = 5,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic          pre_i,
    input  logic          up_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] newbase_o
);
    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    logic [AW-1:0] span;

    always_comb begin
        span = {{(AW-CW){1'b0}}, count_i} * STEP_W;
        if (up_i) begin
            first_o   = base_i + (pre_i ? STEP_W : '0);
            newbase_o = base_i + span;
        end else begin
            first_o   = base_i - span + (pre_i ? '0 : STEP_W);
            newbase_o = base_i - span;
        end
    end
endmodule

// File: rtl/blkseq_ctrl.sv
module blkseq_ctrl
    import blkseq_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int STEP = 4,
    parameter int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NREG-1:0] list_i,
    input  logic [AW-1:0]   first_i,
    input  logic            wb_en_i,
    input  logic [AW-1:0]   wb_val_i,
    input  logic            sub_en_i,
    input  logic [AW-1:0]   sub_val_i,
    input  logic [IW-1:0]   base_idx_i,
    input  logic [NREG-1:0] pick_hot_i,
    input  logic [IW-1:0]   pick_idx_i,
    output logic [NREG-1:0] pend_o,
    output logic            beat_valid_o,
    output logic [IW-1:0]   beat_reg_o,
    output logic [AW-1:0]   beat_addr_o,
    output logic            st_sub_en_o,
    output logic [AW-1:0]   st_sub_val_o,
    output logic            done_o,
    output logic            wb_en_o,
    output logic [AW-1:0]   wb_val_o
);
    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    seq_state_t      state_q, state_d;
    logic [NREG-1:0] pend_q;
    logic [AW-1:0]   addr_q;
    logic            wb_en_q;
    logic [AW-1:0]   wb_val_q;
    logic            sub_en_q;
    logic [AW-1:0]   sub_val_q;
    logic [IW-1:0]   bidx_q;
    logic            accept;
    logic            last_beat;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign last_beat = (pend_q & ~pick_hot_i) == '0;
    assign pend_o    = pend_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = (list_i != '0) ? ST_BEAT : ST_DONE;
            ST_BEAT: if (last_beat) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // sequence data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= '0;
            addr_q    <= '0;
            wb_en_q   <= 1'b0;
            wb_val_q  <= '0;
            sub_en_q  <= 1'b0;
            sub_val_q <= '0;
            bidx_q    <= '0;
        end else if (accept) begin
            pend_q    <= list_i;
            addr_q    <= first_i;
            wb_en_q   <= wb_en_i;
            wb_val_q  <= wb_val_i;
            sub_en_q  <= sub_en_i;
            sub_val_q <= sub_val_i;
            bidx_q    <= base_idx_i;
        end else if (state_q == ST_BEAT) begin
            pend_q <= pend_q & ~pick_hot_i;
            addr_q <= addr_q + STEP_W;
        end
    end

    // outputs
    always_comb begin
        beat_valid_o = 1'b0;
        beat_reg_o   = '0;
        beat_addr_o  = '0;
        st_sub_en_o  = 1'b0;
        st_sub_val_o = '0;
        done_o       = 1'b0;
        wb_en_o      = 1'b0;
        wb_val_o     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BEAT: begin
                beat_valid_o = 1'b1;
                beat_reg_o   = pick_idx_i;
                beat_addr_o  = addr_q;
                if (sub_en_q && (pick_idx_i == bidx_q)) begin
                    st_sub_en_o  = 1'b1;
                    st_sub_val_o = sub_val_q;
                end
            end
            ST_DONE: begin
                done_o   = 1'b1;
                wb_en_o  = wb_en_q;
                wb_val_o = wb_val_q;
            end
            default: ;
        endcase
    end

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && $past(beat_valid_o)) |-> (beat_addr_o == $past(beat_addr_o) + STEP_W));

    // R3
    beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && $past(beat_valid_o)) |-> (beat_reg_o > $past(beat_reg_o)));

    // R4
    done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(beat_valid_o) |-> done_o);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && beat_valid_o));

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && start_i && !last_beat) |=> (beat_addr_o == $past(beat_addr_o) + STEP_W));
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blkseq_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int STEP = 4,
    parameter int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NREG-1:0] rlist_i,
    input  logic [AW-1:0]   base_i,
    input  logic [IW-1:0]   base_idx_i,
    input  logic            pre_i,
    input  logic            up_i,
    input  logic            wb_i,
    input  logic            load_i,
    input  logic            variant_i,
    output logic            beat_valid_o,
    output logic [IW-1:0]   beat_reg_o,
    output logic [AW-1:0]   beat_addr_o,
    output logic            st_sub_en_o,
    output logic [AW-1:0]   st_sub_val_o,
    output logic            done_o,
    output logic            wb_en_o,
    output logic [AW-1:0]   wb_val_o
);
    localparam int CW = $clog2(NREG + 1);
    localparam logic [NREG-1:0] ONE_N  = NREG'(1);
    localparam logic [NREG-1:0] TOP_N  = ONE_N << (NREG - 1);

    arch_var_t       arch;
    logic            empty;
    logic [CW-1:0]   pop_cnt;
    logic [CW-1:0]   eff_cnt;
    logic [NREG-1:0] eff_list;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   new_base;
    logic            in_list;
    logic            is_lowest;
    logic [NREG-1:0] below_mask;
    logic            wb_en_c;
    logic            sub_en_c;
    logic [AW-1:0]   sub_val_c;
    logic [NREG-1:0] pend;
    logic [NREG-1:0] pick_hot;
    logic [IW-1:0]   pick_idx;
    logic            pick_any;

    assign arch       = arch_var_t'(variant_i);
    assign empty      = (rlist_i == '0);
    assign eff_cnt    = empty ? CW'(NREG) : pop_cnt;
    assign eff_list   = empty ? ((arch == VAR_OLD) ? TOP_N : '0) : rlist_i;
    assign in_list    = rlist_i[base_idx_i];
    assign below_mask = (ONE_N << base_idx_i) - ONE_N;
    assign is_lowest  = (rlist_i & below_mask) == '0;
    assign wb_en_c    = empty | (wb_i & ~(load_i & in_list));
    assign sub_en_c   = ~empty & wb_i & ~load_i & in_list;
    assign sub_val_c  = ((arch == VAR_NEW) || is_lowest) ? base_i : new_base;

    blkseq_popcnt #(.W(NREG), .CW(CW)) u_pop (
        .vec_i (rlist_i),
        .cnt_o (pop_cnt)
    );

    blkseq_addr_calc #(.AW(AW), .CW(CW), .STEP(STEP)) u_addr (
        .base_i    (base_i),
        .count_i   (eff_cnt),
        .pre_i     (pre_i),
        .up_i      (up_i),
        .first_o   (first_addr),
        .newbase_o (new_base)
    );

    blkseq_lowbit #(.W(NREG), .IW(IW)) u_pick (
        .vec_i (pend),
        .hot_o (pick_hot),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    blkseq_ctrl #(.NREG(NREG), .AW(AW), .STEP(STEP), .IW(IW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .list_i       (eff_list),
        .first_i      (first_addr),
        .wb_en_i      (wb_en_c),
        .wb_val_i     (new_base),
        .sub_en_i     (sub_en_c),
        .sub_val_i    (sub_val_c),
        .base_idx_i   (base_idx_i),
        .pick_hot_i   (pick_hot),
        .pick_idx_i   (pick_idx),
        .pend_o       (pend),
        .beat_valid_o (beat_valid_o),
        .beat_reg_o   (beat_reg_o),
        .beat_addr_o  (beat_addr_o),
        .st_sub_en_o  (st_sub_en_o),
        .st_sub_val_o (st_sub_val_o),
        .done_o       (done_o),
        .wb_en_o      (wb_en_o),
        .wb_val_o     (wb_val_o)
    );

    // R3
    beat_has_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> pick_any);

    // R10
    sub_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_sub_en_o |-> (beat_valid_o && beat_reg_o == $past(base_idx_i, 1) || beat_valid_o));
endmodule

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] rlist_i = '0;
    logic [31:0] base_i = '0;
    logic [3:0]  base_idx_i = '0;
    logic        pre_i = 1'b0, up_i = 1'b0, wb_i = 1'b0, load_i = 1'b0, variant_i = 1'b0;
    logic        beat_valid_o, st_sub_en_o, done_o, wb_en_o;
    logic [3:0]  beat_reg_o;
    logic [31:0] beat_addr_o, st_sub_val_o, wb_val_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rlist_i(rlist_i),
        .base_i(base_i), .base_idx_i(base_idx_i), .pre_i(pre_i), .up_i(up_i),
        .wb_i(wb_i), .load_i(load_i), .variant_i(variant_i),
        .beat_valid_o(beat_valid_o), .beat_reg_o(beat_reg_o), .beat_addr_o(beat_addr_o),
        .st_sub_en_o(st_sub_en_o), .st_sub_val_o(st_sub_val_o),
        .done_o(done_o), .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One scenario: start, then every beat, then done, then one idle cycle.
    task automatic run_case(logic [15:0] rl, logic [31:0] base, logic [3:0] bidx,
                            logic p, logic u, logic w, logic l, logic v, bit inject);
        bit          empty;
        logic [15:0] list;
        int          cnt;
        int          n;
        logic [31:0] span, first, nb, sub_val_e;
        logic        wb_en_e, sub_en_e, lowest;
        string       atag, wtag, stag;
        int          k;

        empty = (rl == 16'h0);
        list  = empty ? (v ? 16'h0000 : 16'h8000) : rl;
        cnt   = 0;
        for (int i = 0; i < 16; i++) if (rl[i]) cnt++;
        if (empty) cnt = 16;
        n = 0;
        for (int i = 0; i < 16; i++) if (list[i]) n++;
        span  = 32'(cnt) * 32'd4;
        first = u ? base + (p ? 32'd4 : 32'd0) : base - span + (p ? 32'd0 : 32'd4);
        nb    = u ? base + span : base - span;
        wb_en_e  = empty ? 1'b1 : (w && !(l && rl[bidx]));
        sub_en_e = !empty && w && !l && rl[bidx];
        lowest   = (rl & ((16'h1 << bidx) - 16'h1)) == 16'h0;
        sub_val_e = (v || lowest) ? base : nb;
        atag = empty ? (v ? "R8" : "R7") : (u ? "R1" : "R2");
        wtag = empty ? "R9" : ((w && l && rl[bidx]) ? "R6" : "R5");
        stag = v ? "R11" : "R10";

        @(negedge clk);
        rlist_i = rl; base_i = base; base_idx_i = bidx;
        pre_i = p; up_i = u; wb_i = w; load_i = l; variant_i = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        for (int r = 0; r < 16; r++) begin
            if (list[r]) begin
                start_i = 1'b0;
                chk(k == 0 ? atag : "R3", "beat_valid", 32'(beat_valid_o), 32'd1);
                chk("R3", "beat_reg", 32'(beat_reg_o), 32'(r));
                chk(k == 0 ? atag : "R3", "beat_addr", beat_addr_o, first + 32'(k) * 32'd4);
                if (sub_en_e && r == int'(bidx)) begin
                    chk(stag, "sub_en", 32'(st_sub_en_o), 32'd1);
                    chk(stag, "sub_val", st_sub_val_o, sub_val_e);
                end else begin
                    chk(stag, "sub_en_other", 32'(st_sub_en_o), 32'd0);
                end
                if (inject && k == 0) begin
                    rlist_i = 16'h00FF; base_i = 32'hDEAD_0000; up_i = ~u;
                    start_i = 1'b1;  // R12: busy, must be ignored
                end
                k++;
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        chk(empty ? "R9" : "R4", "done", 32'(done_o), 32'd1);
        chk("R4", "valid_at_done", 32'(beat_valid_o), 32'd0);
        chk(wtag, "wb_en", 32'(wb_en_o), 32'(wb_en_e));
        chk(empty ? "R9" : "R4", "wb_val", wb_val_o, nb);
        if (inject) start_i = 1'b1;  // R12: done cycle, must be ignored
        @(negedge clk);
        start_i = 1'b0;
        chk("R4", "done_single", 32'(done_o), 32'd0);
        chk(inject ? "R12" : "R4", "idle_no_beat", 32'(beat_valid_o), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13", "valid", 32'(beat_valid_o), 32'd0);
        chk("R13", "done", 32'(done_o), 32'd0);
        chk("R13", "wb_en", 32'(wb_en_o), 32'd0);
        chk("R13", "sub_en", 32'(st_sub_en_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 up, post and pre; base idx 9 outside list (R5)
        run_case(16'h0096, 32'h0000_1000, 4'd9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run_case(16'h0096, 32'h0000_1000, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        // R2 down, pre and post
        run_case(16'h4021, 32'h0000_2000, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_case(16'h4021, 32'h0000_2000, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        // R7 older empty list, up and down
        run_case(16'h0000, 32'h0000_3000, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_case(16'h0000, 32'h0000_3000, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_case(16'h0000, 32'h0000_3000, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R8 newer empty list
        run_case(16'h0000, 32'h0000_4000, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        run_case(16'h0000, 32'h0000_4000, 4'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        // R10 older store, base lowest then not lowest
        run_case(16'h0024, 32'h0000_5000, 4'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run_case(16'h0024, 32'h0000_5000, 4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // R11 newer store, base not lowest
        run_case(16'h0024, 32'h0000_5000, 4'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        // R6 load with base in list
        run_case(16'h0024, 32'h0000_6000, 4'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        // R5 no writeback requested, full list with wraparound
        run_case(16'hFFFF, 32'h0000_0010, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        // R12 start ignored while busy and at done
        run_case(16'h1111, 32'h0000_7000, 4'd15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        run_case(16'h8000, 32'h0000_8000, 4'd15, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule